// File: doc/BRIEF.md
# Vector branch condition reducer

This block turns a vector of 4-bit condition fields into one branch decision for a vectorised conditional branch. After a start pulse it walks the elements in ascending order, one position per clock. From each element's condition field it picks one bit, tests that bit against the branch option bits, and folds the outcome into a running result. In "all" mode the result is an AND across the elements. In "any" mode it is an OR. The scan stops early as soon as the result can no longer change.

A predicate mask decides which elements take part. Masked-out elements are either skipped, or tested with a fixed substitute bit. An optional side effect reports a truncated vector length at the first element whose outcome matches a chosen polarity. When the scan ends, a one-cycle done pulse marks the final result, the number of elements tested and the optional new length. The caller holds the condition-field vector and the predicate mask stable from the start pulse until done.

Top module: `vec_branch_reduce`

## Requirements
- R1: The element field index is computed as follows.
  - The base field index is `{bsel_i[4:2], bext_i}`.
  - For a vector scan, element i uses field (base + i) modulo NUM_FIELDS. For a scalar scan (`vec_i`=0), every element uses the base field.
  - Field f occupies `cr_fields_i[4f+3:4f]`. `bsel_i[1:0]`=k selects bit k of that field.
- R2: The running result starts equal to `all_i`. A vector length of zero ends the scan with `cond_o`=`all_i`, `tested_o`=0 and `vl_new_valid_o`=0.
- R3: An element passes when `bo_i[0]` is 1, or when its test bit equals `bo_i[1]`.
- R4: The early exits depend on the mode. If no exit is taken, the result stays at its initial value.
  - With `all_i`=1, the first failing element ends the scan with `cond_o`=0.
  - With `all_i`=0, the first passing element ends the scan with `cond_o`=1.
- R5: Elements are visited in ascending order and nothing beyond the exit element is tested. `tested_o` equals the number of elements tested up to and including the exit point.
- R6: With `sz_i`=0, an element whose predicate bit (`pred_i[i]`) is 0 is skipped. It is neither tested nor counted.
- R7: With `sz_i`=1, an element whose predicate bit is 0 is tested and counted, and `snz_i` stands in for its test bit.
- R8: In a scalar scan, only the first element that takes part is tested, after which the scan ends.
- R9: This requirement covers length truncation.
  - With `vlset_i`=1, the scan ends at the first tested element i whose pass value equals `vsb_i`.
  - At that point `vl_new_valid_o`=1 and `vl_new_o` is i+1 when `vli_i`=1, or i when `vli_i`=0.
  - Otherwise `vl_new_valid_o`=0.
- R10: Timing of a scan.
  - One element position is visited per clock.
  - `done_o` is high for exactly one cycle, L clock edges after the edge that samples `start_i`. L is the index of the last visited position plus one, or 1 for a zero length.
  - Results stay held until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a scan (accepted when idle) |
| cr_fields_i | input | NUM_FIELDS*4 | All condition fields, field f at bits 4f+3..4f |
| bsel_i | input | 5 | Bit selector: [1:0] bit in field, [4:2] upper base bits |
| bext_i | input | log2(NUM_FIELDS)-3 | Extension forming the low base-field bits |
| vec_i | input | 1 | 1 = vector of fields, 0 = scalar field |
| vl_i | input | log2(MAX_VL+1) | Vector length, 0..MAX_VL |
| pred_i | input | MAX_VL | Predicate mask, bit i for element i |
| bo_i | input | 2 | Branch option bits: [0] always-pass, [1] expected bit value |
| all_i | input | 1 | 1 = AND reduction, 0 = OR reduction |
| sz_i | input | 1 | Test masked-out elements with a substitute bit |
| snz_i | input | 1 | Substitute test bit for masked-out elements |
| vlset_i | input | 1 | Enable length truncation |
| vsb_i | input | 1 | Pass value that triggers truncation |
| vli_i | input | 1 | Truncated length includes the trigger element |
| cond_o | output | 1 | Final branch condition result |
| vl_new_valid_o | output | 1 | Truncated length is valid |
| vl_new_o | output | log2(MAX_VL+1) | Truncated vector length |
| tested_o | output | log2(MAX_VL+1) | Number of elements tested |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The assertions check the following on every cycle:
- done lasts only one cycle;
- the tested count never exceeds the length;
- a scalar scan tests at most one element;
- a skipped element leaves the count unchanged;
- a reported new length is no greater than the length and only appears with truncation enabled;
- a zero length returns the initial result;
- a failed all-mode scan has tested something.

Only the bench's scenarios can show the following:
- that the right field and bit are chosen;
- that the exit happens at the exact element a reference scan predicts;
- the substitute-bit behaviour;
- the inclusive or exclusive truncation value;
- the latency.

// File: rtl/vbr_pkg.sv
package vbr_pkg;

    localparam int FLD_W = 4;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } vbr_state_e;

    typedef struct packed {
        logic       all;
        logic       sz;
        logic       snz;
        logic       vlset;
        logic       vsb;
        logic       vli;
        logic       vec;
        logic [1:0] bo;
    } vbr_mode_t;

    // Element test: always-pass bit, or test bit matches expected value
    function automatic logic elem_pass(logic bo_any, logic bo_val, logic tbit);
        return bo_any | ~(tbit ^ bo_val);
    endfunction

    // Fold one outcome into the running result
    function automatic logic fold_step(logic all_m, logic acc, logic pass);
        return all_m ? (acc & pass) : (acc | pass);
    endfunction

    // Outcome that settles the reduction for good
    function automatic logic settles(logic all_m, logic pass);
        return all_m ? ~pass : pass;
    endfunction

endpackage

// File: rtl/vbr_field_pick.sv
module vbr_field_pick #(
    parameter int NUM_FIELDS = 128,
    parameter int IDX_W      = 6,
    parameter int FIDX_W     = $clog2(NUM_FIELDS)
) (
    input  logic [NUM_FIELDS*vbr_pkg::FLD_W-1:0] fields,
    input  logic [FIDX_W-1:0]                    base,
    input  logic [IDX_W-1:0]                     idx,
    input  logic                                 vec,
    input  logic [1:0]                           bit_sel,
    output logic                                 bit_o
);
    logic [FIDX_W-1:0]         fld;
    logic [vbr_pkg::FLD_W-1:0] nib;

    always_comb begin
        fld   = vec ? (base + FIDX_W'(idx)) : base;
        nib   = fields[fld*vbr_pkg::FLD_W +: vbr_pkg::FLD_W];
        bit_o = nib[bit_sel];
    end
endmodule

// File: rtl/vbr_elem_eval.sv
module vbr_elem_eval (
    input  logic       pred_bit,
    input  logic       sz,
    input  logic       snz,
    input  logic       cr_bit,
    input  logic [1:0] bo,
    output logic       active,
    output logic       pass
);
    import vbr_pkg::*;
    logic tbit;

    always_comb begin
        active = pred_bit | sz;
        tbit   = pred_bit ? cr_bit : snz;
        pass   = elem_pass(bo[0], bo[1], tbit);
    end
endmodule

// File: rtl/vec_branch_reduce.sv
module vec_branch_reduce #(
    parameter int NUM_FIELDS = 128,
    parameter int MAX_VL     = 64,
    parameter int FIDX_W     = $clog2(NUM_FIELDS),
    parameter int LEN_W      = $clog2(MAX_VL + 1)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           start_i,
    input  logic [NUM_FIELDS*4-1:0]        cr_fields_i,
    input  logic [4:0]                     bsel_i,
    input  logic [FIDX_W-4:0]              bext_i,
    input  logic                           vec_i,
    input  logic [LEN_W-1:0]               vl_i,
    input  logic [MAX_VL-1:0]              pred_i,
    input  logic [1:0]                     bo_i,
    input  logic                           all_i,
    input  logic                           sz_i,
    input  logic                           snz_i,
    input  logic                           vlset_i,
    input  logic                           vsb_i,
    input  logic                           vli_i,
    output logic                           cond_o,
    output logic                           vl_new_valid_o,
    output logic [LEN_W-1:0]               vl_new_o,
    output logic [LEN_W-1:0]               tested_o,
    output logic                           done_o
);
    import vbr_pkg::*;

    localparam int IDX_W = (MAX_VL > 1) ? $clog2(MAX_VL) : 1;

    vbr_state_e        state_q;
    vbr_mode_t         mode_q;
    logic [LEN_W-1:0]  vl_q;
    logic [FIDX_W-1:0] base_q;
    logic [1:0]        bit_q;
    logic [IDX_W-1:0]  idx_q;
    logic              acc_q;
    logic [LEN_W-1:0]  cnt_q;
    logic              vlv_q;
    logic [LEN_W-1:0]  vln_q;
    logic              done_q;

    logic cr_bit, el_act, el_pass;
    logic ex_red, ex_vl, ex_sc, at_last, finish;
    logic [LEN_W-1:0] idx_len;

    vbr_field_pick #(
        .NUM_FIELDS(NUM_FIELDS),
        .IDX_W     (IDX_W),
        .FIDX_W    (FIDX_W)
    ) u_pick (
        .fields (cr_fields_i),
        .base   (base_q),
        .idx    (idx_q),
        .vec    (mode_q.vec),
        .bit_sel(bit_q),
        .bit_o  (cr_bit)
    );

    vbr_elem_eval u_eval (
        .pred_bit(pred_i[idx_q]),
        .sz      (mode_q.sz),
        .snz     (mode_q.snz),
        .cr_bit  (cr_bit),
        .bo      (mode_q.bo),
        .active  (el_act),
        .pass    (el_pass)
    );

    always_comb begin
        idx_len = LEN_W'(idx_q);
        ex_red  = el_act & settles(mode_q.all, el_pass);
        ex_vl   = el_act & mode_q.vlset & (el_pass == mode_q.vsb);
        ex_sc   = el_act & ~mode_q.vec;
        at_last = (idx_len == vl_q - LEN_W'(1));
        finish  = ex_red | ex_vl | ex_sc | at_last;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= '0;
            vl_q    <= '0;
            base_q  <= '0;
            bit_q   <= '0;
            idx_q   <= '0;
            acc_q   <= 1'b0;
            cnt_q   <= '0;
            vlv_q   <= 1'b0;
            vln_q   <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        mode_q  <= '{all: all_i, sz: sz_i, snz: snz_i, vlset: vlset_i,
                                     vsb: vsb_i, vli: vli_i, vec: vec_i, bo: bo_i};
                        vl_q    <= vl_i;
                        base_q  <= {bsel_i[4:2], bext_i};
                        bit_q   <= bsel_i[1:0];
                        idx_q   <= '0;
                        acc_q   <= all_i;
                        cnt_q   <= '0;
                        vlv_q   <= 1'b0;
                        vln_q   <= '0;
                        state_q <= ST_SCAN;
                    end
                end
                default: begin
                    if (vl_q == '0) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else begin
                        if (el_act) begin
                            acc_q <= fold_step(mode_q.all, acc_q, el_pass);
                            cnt_q <= cnt_q + LEN_W'(1);
                        end
                        if (ex_vl) begin
                            vlv_q <= 1'b1;
                            vln_q <= mode_q.vli ? idx_len + LEN_W'(1) : idx_len;
                        end
                        if (finish) begin
                            done_q  <= 1'b1;
                            state_q <= ST_IDLE;
                        end else begin
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end
                end
            endcase
        end
    end

    assign cond_o         = acc_q;
    assign vl_new_valid_o = vlv_q;
    assign vl_new_o       = vln_q;
    assign tested_o       = cnt_q;
    assign done_o         = done_q;

    // R10: completion is a single-cycle pulse
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q);

    // R5: never more tested than the vector length
    assert_count_bound_R5: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (cnt_q <= vl_q));

    // R8: a scalar scan tests at most one element
    assert_scalar_single_R8: assert property (@(posedge clk) disable iff (rst)
        (done_q && !mode_q.vec) |-> (cnt_q <= LEN_W'(1)));

    // R6: a skipped element leaves the count untouched
    assert_skip_stable_R6: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SCAN && vl_q != '0 && !mode_q.sz && !pred_i[idx_q])
        |=> $stable(cnt_q));

    // R9: a new length only with truncation enabled and never above the length
    assert_newlen_bound_R9: assert property (@(posedge clk) disable iff (rst)
        (done_q && vlv_q) |-> (mode_q.vlset && vln_q <= vl_q));

    // R2: zero length keeps the initial result
    assert_empty_scan_R2: assert property (@(posedge clk) disable iff (rst)
        (done_q && vl_q == '0) |-> (cnt_q == '0 && acc_q == mode_q.all && !vlv_q));

    // R4: an all-mode failure needs at least one tested element
    assert_all_fail_R4: assert property (@(posedge clk) disable iff (rst)
        (done_q && mode_q.all && !acc_q) |-> (cnt_q != '0));
endmodule

// File: tb/vec_branch_reduce_bench.sv
module vec_branch_reduce_bench;
    localparam int NF = 128;
    localparam int MV = 64;

    logic            clk = 1'b0;
    logic            rst;
    logic            start_i;
    logic [NF*4-1:0] cr_fields_i;
    logic [4:0]      bsel_i;
    logic [3:0]      bext_i;
    logic            vec_i;
    logic [6:0]      vl_i;
    logic [MV-1:0]   pred_i;
    logic [1:0]      bo_i;
    logic all_i, sz_i, snz_i, vlset_i, vsb_i, vli_i;
    logic            cond_o, vl_new_valid_o, done_o;
    logic [6:0]      vl_new_o, tested_o;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    vec_branch_reduce u_vec_branch_reduce (
        .clk(clk), .rst(rst), .start_i(start_i), .cr_fields_i(cr_fields_i),
        .bsel_i(bsel_i), .bext_i(bext_i), .vec_i(vec_i), .vl_i(vl_i),
        .pred_i(pred_i), .bo_i(bo_i), .all_i(all_i), .sz_i(sz_i), .snz_i(snz_i),
        .vlset_i(vlset_i), .vsb_i(vsb_i), .vli_i(vli_i), .cond_o(cond_o),
        .vl_new_valid_o(vl_new_valid_o), .vl_new_o(vl_new_o),
        .tested_o(tested_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference scan computed from the requirements
    int e_res, e_cnt, e_vlv, e_vln, e_lat;
    task automatic model();
        int base, last;
        base  = {bsel_i[4:2], bext_i};
        e_res = all_i; e_cnt = 0; e_vlv = 0; e_vln = 0; last = 0;
        if (vl_i == 0) begin
            e_lat = 1;
            return;
        end
        for (int i = 0; i < int'(vl_i); i++) begin
            bit act, tb, pass, ex;
            int f;
            last = i;
            act  = pred_i[i] | sz_i;
            if (act) begin
                f    = vec_i ? ((base + i) % NF) : base;
                tb   = pred_i[i] ? cr_fields_i[f*4 + int'(bsel_i[1:0])] : snz_i;
                pass = bo_i[0] | (tb == bo_i[1]);
                e_cnt++;
                e_res = all_i ? (e_res & pass) : (e_res | pass);
                ex = 0;
                if (vlset_i && pass == vsb_i) begin
                    e_vlv = 1; e_vln = vli_i ? i + 1 : i; ex = 1;
                end
                if (all_i ? !pass : pass) ex = 1;
                if (!vec_i) ex = 1;
                if (ex) break;
            end
        end
        e_lat = last + 1;
    endtask

    task automatic run_case(input string tag);
        int cyc;
        model();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        cyc = 0;
        while (!done_o && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        chk(done_o == 1'b1 && cyc == e_lat, {tag, " R10 latency"}, cyc, e_lat);
        chk(cond_o == e_res[0], {tag, " R4 result"}, int'(cond_o), e_res);
        chk(int'(tested_o) == e_cnt, {tag, " R5 tested"}, int'(tested_o), e_cnt);
        chk(int'(vl_new_valid_o) == e_vlv, {tag, " R9 valid"}, int'(vl_new_valid_o), e_vlv);
        if (e_vlv != 0)
            chk(int'(vl_new_o) == e_vln, {tag, " R9 length"}, int'(vl_new_o), e_vln);
        @(negedge clk);
        chk(done_o == 1'b0, {tag, " R10 pulse"}, int'(done_o), 0);
    endtask

    task automatic defaults();
        cr_fields_i = '0; bsel_i = '0; bext_i = '0; vec_i = 1'b1; vl_i = 7'd4;
        pred_i = '1; bo_i = 2'b10; all_i = 1'b0; sz_i = 1'b0; snz_i = 1'b0;
        vlset_i = 1'b0; vsb_i = 1'b0; vli_i = 1'b0;
    endtask

    task automatic rand_fields();
        for (int w = 0; w < NF*4/32; w++) cr_fields_i[w*32 +: 32] = $urandom;
    endtask

    initial begin
        #4000000;
        n_checks++; n_errors++;
        $display("FAIL watchdog R10 actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        defaults();
        start_i = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(done_o == 1'b0 && cond_o == 1'b0 && tested_o == 0 && !vl_new_valid_o,
            "reset R10", int'(done_o), 0);

        // R2: zero length in both reduction modes
        defaults(); vl_i = 0; all_i = 1'b1; run_case("zero-all R2");
        defaults(); vl_i = 0; all_i = 1'b0; run_case("zero-any R2");

        // R1: field/bit select; base 37, bit 2, field 39 holds the only set bit
        defaults(); bsel_i = {3'd2, 2'd2}; bext_i = 4'd5; vl_i = 8;
        cr_fields_i[39*4 + 2] = 1'b1; run_case("select R1");
        // R1: wrap of the field index modulo 128
        defaults(); bsel_i = {3'd7, 2'd1}; bext_i = 4'd15; vl_i = 6;
        cr_fields_i[2*4 + 1] = 1'b1; run_case("wrap R1");

        // R3: always-pass bit makes the first element pass
        defaults(); bo_i = 2'b01; all_i = 1'b0; run_case("always R3");
        // R3/R4: all mode, expect zeros, fail at element 3
        defaults(); bo_i = 2'b00; all_i = 1'b1; vl_i = 10; cr_fields_i[3*4] = 1'b1;
        run_case("allfail R3 R4");
        // R4: all mode with no failure runs to the end
        defaults(); bo_i = 2'b00; all_i = 1'b1; vl_i = 64; run_case("allpass R4");

        // R6: skipped elements, only element 5 takes part and passes
        defaults(); pred_i = 64'h20; cr_fields_i[5*4] = 1'b1; vl_i = 9; run_case("skip R6");
        // R7: substitute bit one for masked elements in any mode
        defaults(); pred_i = 64'h0; sz_i = 1'b1; snz_i = 1'b1; run_case("subst R7");
        // R7: substitute zero, all mode expecting ones, fails at element 2
        defaults(); all_i = 1'b1; pred_i = ~64'h4; sz_i = 1'b1;
        cr_fields_i = '1; run_case("subst-fail R7");

        // R8: scalar field, first predicated element is 3
        defaults(); vec_i = 1'b0; pred_i = 64'h18; vl_i = 20; run_case("scalar R8");

        // R9: truncation inclusive and exclusive at element 4
        defaults(); all_i = 1'b1; bo_i = 2'b00; vlset_i = 1'b1; vsb_i = 1'b0; vli_i = 1'b1;
        vl_i = 12; cr_fields_i[4*4] = 1'b1; run_case("vlset-incl R9");
        defaults(); all_i = 1'b1; bo_i = 2'b00; vlset_i = 1'b1; vsb_i = 1'b0; vli_i = 1'b0;
        vl_i = 12; cr_fields_i[4*4] = 1'b1; run_case("vlset-excl R9");

        // Random scenarios over every mode bit
        for (int t = 0; t < 400; t++) begin
            defaults();
            rand_fields();
            bsel_i  = 5'($urandom); bext_i = 4'($urandom);
            vec_i   = ($urandom % 5) != 0;
            vl_i    = 7'($urandom % (MV + 1));
            pred_i  = {$urandom, $urandom};
            if ($urandom % 2) pred_i = pred_i & {$urandom, $urandom} & {$urandom, $urandom};
            bo_i    = 2'($urandom); if (bo_i[0] && ($urandom % 2)) bo_i[0] = 1'b0;
            all_i   = 1'($urandom); sz_i = 1'($urandom); snz_i = 1'($urandom);
            vlset_i = 1'($urandom); vsb_i = 1'($urandom); vli_i = 1'($urandom);
            run_case("random R1 R3 R6 R7 R8");
        end

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule